// File: doc/BRIEF.md
# Paged Program Counter with Circular Return Stack

This unit sequences instruction addresses for a small processor with 14-bit instruction words. It holds a 13-bit program counter and an eight-entry, 13-bit return stack. Decoded command strobes drive it: step to the next address, branch within a page, call a subroutine, overwrite the low byte of the counter, return, and enter an interrupt. A separately written 5-bit page latch supplies the upper address bits. Branches take their two top bits from the latch. A low-byte write takes all five latch bits.

The stack pointer cannot be seen from outside. The stack never overflows or underflows. Its pointer wraps, so old entries are overwritten and extra pops read stale entries, and nothing is flagged. A return restores all 13 bits from the stack and leaves the latch alone.

When more than one command strobe is high in a cycle, a fixed priority picks one. A latch write is independent of the command strobes and takes effect on the following cycle.

Top module: `pc_seq_unit`

## Requirements
- R1: While reset is low, the counter, the page latch, the stack pointer and every stack entry go to zero, so after reset `pc_o` = 0x0000 and `latch_o` = 0.
- R2: An increment command sets the counter to its previous value plus one, modulo 8192 (0x1FFF steps to 0x0000).
- R3: A jump command loads counter bits 10:0 from `target_i` and bits 12:11 from page latch bits 4:3.
- R4: A call command pushes the counter value plus one onto the stack and loads the counter as a jump does.
- R5: A low-byte write loads counter bits 7:0 from `wdata_i` and bits 12:8 from page latch bits 4:0.
- R6: An interrupt command pushes the current counter value unchanged and loads the counter with 0x004.
- R7: A return pops the most recently pushed entry into all 13 counter bits. Neither a push nor a pop changes the page latch.
- R8: The stack has eight entries and wraps. After nine pushes, the ninth value has replaced the first, and later pops yield the values from the ninth push down to the second.
- R9: A pop with no matching push wraps the pointer and loads whatever the selected entry holds, which is zero if the entry was cleared by reset and never written. No error is flagged.
- R10: Command priority, highest first, is interrupt, return, call, jump, low-byte write, increment. A low-byte write or branch issued in the same cycle as a latch write uses the old latch value.
- R11: A latch write loads the latch from `wdata_i` bits 4:0 and does not change the counter by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| inc_i | input | 1 | Increment command |
| jump_i | input | 1 | In-page jump command |
| call_i | input | 1 | Call command (push and jump) |
| pcl_wr_i | input | 1 | Low-byte write command |
| ret_i | input | 1 | Return command (pop) |
| irq_i | input | 1 | Interrupt entry command |
| latch_wr_i | input | 1 | Page latch write strobe |
| target_i | input | 11 | Branch target within the page |
| wdata_i | input | 8 | Write data for the low byte and the latch |
| pc_o | output | 13 | Current program counter |
| latch_o | output | 5 | Current page latch value |

## Verification
Several behaviours are checked on every cycle:
- the arbiter picks the interrupt and return commands ahead of the others;
- a pushed value shows at the top of the stack on the next cycle;
- each pop moves the hidden pointer down by one;
- the latch holds its value unless it is written;
- increments, jumps, returns and interrupt entry each produce the correct counter value one cycle later.

Some behaviours only the bench's sequences can show, because they depend on history: the stack wrapping after nine calls, the order in which values come back from a long run of pops, a pop on an empty stack returning a cleared entry, and a branch that uses the old latch value in the same cycle as a latch write.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_INC  = 3'd1,
    OP_PCLW = 3'd2,
    OP_JUMP = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5,
    OP_IRQ  = 3'd6
  } pc_op_e;

  // Fixed priority: interrupt, return, call, jump, low-byte write, increment.
  function automatic pc_op_e pick_op(input logic inc, input logic pclw,
                                     input logic jump, input logic call,
                                     input logic ret, input logic irq);
    if (irq)       return OP_IRQ;
    else if (ret)  return OP_RET;
    else if (call) return OP_CALL;
    else if (jump) return OP_JUMP;
    else if (pclw) return OP_PCLW;
    else if (inc)  return OP_INC;
    else           return OP_NONE;
  endfunction

endpackage

// File: rtl/pcu_cmd_arb.sv
module pcu_cmd_arb
  import pcu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   inc_i,
  input  logic   pclw_i,
  input  logic   jump_i,
  input  logic   call_i,
  input  logic   ret_i,
  input  logic   irq_i,
  output pc_op_e op_o
);

  always_comb op_o = pick_op(inc_i, pclw_i, jump_i, call_i, ret_i, irq_i);

  // R10: interrupt entry beats every other command
  a_r10_irq_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irq_i |-> op_o == OP_IRQ);

  // R10: return beats call, jump, low-byte write and increment
  a_r10_ret_over_call: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !irq_i) |-> op_o == OP_RET);

endmodule

// File: rtl/pcu_page_latch.sv
module pcu_page_latch #(
  parameter int LATCH_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [LATCH_W-1:0] wdata_i,
  output logic [LATCH_W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (wr_i) q_o <= wdata_i;
  end

  // R7: the latch moves only on its own write strobe, never on push or pop
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(q_o));

endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);

  // DEPTH must be a power of two so that the pointer wraps naturally.
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] sp_q;
  logic [W-1:0]     ent_q [DEPTH];
  logic [PTR_W-1:0] top_idx;

  assign top_idx = sp_q - PTR_W'(1);
  assign top_o   = ent_q[top_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sp_q <= '0;
    else if (push_i) sp_q <= sp_q + PTR_W'(1);
    else if (pop_i)  sp_q <= sp_q - PTR_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ent_q[g] <= '0;
      else if (push_i && sp_q == PTR_W'(g))    ent_q[g] <= push_data_i;
    end
  end

  // R8: a pushed value is the next one a pop would return
  a_r8_push_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> top_o == $past(push_data_i));

  // R9: every pop steps the pointer down by one, wrapping with no error
  a_r9_pop_steps: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |=> (sp_q + PTR_W'(1)) == $past(sp_q));

  // R10: the arbiter never asks for a push and a pop together
  a_r10_no_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));

endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
  import pcu_pkg::*;
#(
  parameter int PC_W    = 13,
  parameter int DATA_W  = 8,
  parameter int TGT_W   = 11,
  parameter int DEPTH   = 8,
  parameter int VECTOR  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inc_i,
  input  logic                     jump_i,
  input  logic                     call_i,
  input  logic                     pcl_wr_i,
  input  logic                     ret_i,
  input  logic                     irq_i,
  input  logic                     latch_wr_i,
  input  logic [TGT_W-1:0]         target_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [PC_W-1:0]          pc_o,
  output logic [PC_W-DATA_W-1:0]   latch_o
);

  localparam int LATCH_W = PC_W - DATA_W;
  localparam int PAGE_W  = PC_W - TGT_W;
  localparam logic [PC_W-1:0] VEC_ADDR = PC_W'(VECTOR);

  function automatic logic [PC_W-1:0] seq_addr(input logic [PC_W-1:0] p);
    return p + PC_W'(1);
  endfunction

  function automatic logic [PC_W-1:0] page_addr(input logic [LATCH_W-1:0] lat,
                                                input logic [TGT_W-1:0] tgt);
    return {lat[LATCH_W-1 -: PAGE_W], tgt};
  endfunction

  function automatic logic [PC_W-1:0] low_addr(input logic [LATCH_W-1:0] lat,
                                               input logic [DATA_W-1:0] d);
    return {lat, d};
  endfunction

  pc_op_e             op;
  logic [PC_W-1:0]    pc_q, pc_d;
  logic [LATCH_W-1:0] latch_q;
  logic [PC_W-1:0]    stk_top;
  logic               push, pop;
  logic [PC_W-1:0]    push_data;

  pcu_cmd_arb u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (inc_i),
    .pclw_i (pcl_wr_i),
    .jump_i (jump_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .irq_i  (irq_i),
    .op_o   (op)
  );

  pcu_page_latch #(.LATCH_W(LATCH_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (latch_wr_i),
    .wdata_i (wdata_i[LATCH_W-1:0]),
    .q_o     (latch_q)
  );

  assign push      = (op == OP_CALL) || (op == OP_IRQ);
  assign pop       = (op == OP_RET);
  assign push_data = (op == OP_CALL) ? seq_addr(pc_q) : pc_q;

  pcu_ret_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (push_data),
    .top_o       (stk_top)
  );

  always_comb begin
    unique case (op)
      OP_INC:           pc_d = seq_addr(pc_q);
      OP_JUMP, OP_CALL: pc_d = page_addr(latch_q, target_i);
      OP_PCLW:          pc_d = low_addr(latch_q, wdata_i);
      OP_RET:           pc_d = stk_top;
      OP_IRQ:           pc_d = VEC_ADDR;
      default:          pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o    = pc_q;
  assign latch_o = latch_q;

  // R2: increment advances by one, wrapping at the top of the space
  a_r2_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC) |=> pc_q == PC_W'($past(pc_q) + PC_W'(1)));

  // R3: jump keeps the page bits from the latch and the rest from the target
  a_r3_jump_page: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JUMP) |=> (pc_q[PC_W-1 -: PAGE_W] == $past(latch_q[LATCH_W-1 -: PAGE_W]))
                        && (pc_q[TGT_W-1:0] == $past(target_i)));

  // R6: interrupt entry lands on the fixed vector
  a_r6_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IRQ) |=> pc_q == VEC_ADDR);

  // R7: a return restores the whole counter from the top of the stack
  a_r7_ret_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RET) |=> pc_q == $past(stk_top));

  // R11: a latch write on its own leaves the counter where it was
  a_r11_latch_no_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_wr_i && op == OP_NONE) |=> $stable(pc_q));

endmodule

// File: tb/tb_pc_seq_unit.sv
`timescale 1ns/1ps
module tb_pc_seq_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_i = 0, jump_i = 0, call_i = 0, pcl_wr_i = 0;
  logic        ret_i = 0, irq_i = 0, latch_wr_i = 0;
  logic [10:0] target_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [12:0] pc_o;
  logic [4:0]  latch_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pc_seq_unit dut (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .jump_i(jump_i), .call_i(call_i),
    .pcl_wr_i(pcl_wr_i), .ret_i(ret_i), .irq_i(irq_i), .latch_wr_i(latch_wr_i),
    .target_i(target_i), .wdata_i(wdata_i), .pc_o(pc_o), .latch_o(latch_o)
  );

  // op codes used by the bench only
  localparam logic [2:0] B_INC = 3'd1, B_JMP = 3'd2, B_CALL = 3'd3, B_PCLW = 3'd4,
                         B_RET = 3'd5, B_IRQ = 3'd6, B_LAT = 3'd7;

  // {op, operand, expected pc after the cycle}
  localparam int NVEC = 20;
  localparam logic [26:0] VECS [NVEC] = '{
    {B_LAT,  11'h01A, 13'h0000},
    {B_JMP,  11'h123, 13'h1923},
    {B_INC,  11'h000, 13'h1924},
    {B_CALL, 11'h055, 13'h1855},
    {B_INC,  11'h000, 13'h1856},
    {B_PCLW, 11'h09C, 13'h1A9C},
    {B_IRQ,  11'h000, 13'h0004},
    {B_INC,  11'h000, 13'h0005},
    {B_RET,  11'h000, 13'h1A9C},
    {B_RET,  11'h000, 13'h1925},
    {B_LAT,  11'h005, 13'h1925},
    {B_CALL, 11'h7FF, 13'h07FF},
    {B_INC,  11'h000, 13'h0800},
    {B_RET,  11'h000, 13'h1926},
    {B_INC,  11'h000, 13'h1927},
    {B_PCLW, 11'h0FF, 13'h05FF},
    {B_INC,  11'h000, 13'h0600},
    {B_LAT,  11'h01F, 13'h0600},
    {B_PCLW, 11'h0FF, 13'h1FFF},
    {B_INC,  11'h000, 13'h0000}
  };

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      B_INC:  return "R2 increment";
      B_JMP:  return "R3 jump";
      B_CALL: return "R4 call";
      B_PCLW: return "R5 low-byte write";
      B_RET:  return "R7 return";
      B_IRQ:  return "R6 interrupt";
      B_LAT:  return "R11 latch write";
      default: return "none";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_cmds();
    inc_i = 0; jump_i = 0; call_i = 0; pcl_wr_i = 0;
    ret_i = 0; irq_i = 0; latch_wr_i = 0;
  endtask

  // called at a falling edge; returns at the next falling edge with strobes cleared
  task automatic do_op(input logic [2:0] op, input logic [10:0] opnd);
    target_i = opnd;
    wdata_i  = opnd[7:0];
    case (op)
      B_INC:  inc_i = 1;
      B_JMP:  jump_i = 1;
      B_CALL: call_i = 1;
      B_PCLW: pcl_wr_i = 1;
      B_RET:  ret_i = 1;
      B_IRQ:  irq_i = 1;
      B_LAT:  latch_wr_i = 1;
      default: ;
    endcase
    @(negedge clk);
    clear_cmds();
  endtask

  task automatic apply_reset();
    clear_cmds();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    apply_reset();
    check("R1 reset pc", pc_o, 0);
    check("R1 reset latch", latch_o, 0);

    // vector table walk
    for (int i = 0; i < NVEC; i++) begin
      do_op(VECS[i][26:24], VECS[i][23:13]);
      check(op_tag(VECS[i][26:24]), pc_o, VECS[i][12:0]);
    end

    // R8: nine calls in page 3, then nine returns
    do_op(B_LAT, 11'h01F);
    for (int k = 1; k <= 9; k++) begin
      do_op(B_CALL, 11'(k));
      check("R4 call target", pc_o, 13'h1800 + k);
    end
    check("R7 latch unchanged by pushes", latch_o, 5'h1F);
    for (int k = 0; k < 8; k++) begin
      do_op(B_RET, 11'h000);
      check("R8 pop order", pc_o, 13'h1809 - k);
    end
    do_op(B_RET, 11'h000);
    check("R8 first push overwritten by ninth", pc_o, 13'h1809);
    check("R7 latch unchanged by pops", latch_o, 5'h1F);

    // R10: priority among simultaneous strobes
    irq_i = 1; inc_i = 1; ret_i = 1;
    @(negedge clk); clear_cmds();
    check("R10 interrupt over return and increment", pc_o, 13'h0004);
    ret_i = 1; call_i = 1; jump_i = 1; target_i = 11'h111;
    @(negedge clk); clear_cmds();
    check("R10 return over call", pc_o, 13'h1809);
    jump_i = 1; pcl_wr_i = 1; inc_i = 1; target_i = 11'h2AA; wdata_i = 8'h33;
    @(negedge clk); clear_cmds();
    check("R10 jump over low-byte write", pc_o, 13'h1AAA);
    latch_wr_i = 1; pcl_wr_i = 1; wdata_i = 8'h03;
    @(negedge clk); clear_cmds();
    check("R10 low-byte write uses old latch", pc_o, 13'h1F03);
    check("R11 latch loaded", latch_o, 5'h03);
    do_op(B_JMP, 11'h000);
    check("R3 jump uses new page bits", pc_o, 13'h0000);

    // R9: pop past the bottom after reset
    apply_reset();
    do_op(B_JMP, 11'h155);
    do_op(B_CALL, 11'h200);
    do_op(B_RET, 11'h000);
    check("R7 return after call", pc_o, 13'h0156);
    do_op(B_RET, 11'h000);
    check("R9 underflow pop gives cleared entry", pc_o, 13'h0000);
    do_op(B_IRQ, 11'h000);
    do_op(B_RET, 11'h000);
    check("R9 stack usable after underflow", pc_o, 13'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule